// File: doc/BRIEF.md
# Privileged State-Enable Trap Checker

This block holds two enable bits at each of three privilege levels (machine, hypervisor and supervisor) and decides whether the instruction now in decode must trap. One bit gates floating-point instructions on cores that keep floating-point values in the integer register file. The other bit gates the jump-vector-table CSR, and the same bit also gates the table-jump instructions that read that CSR implicitly. An instruction is checked against the machine level first, then the hypervisor level when the hart runs virtualized, then the supervisor level when the hart runs in user mode. A clear machine-level bit raises an illegal-instruction trap. A clear bit at a lower level raises either an illegal-instruction or a virtual-instruction trap, depending on the mode.

Two configuration inputs limit which bits can be set. When a separate floating-point register file is present, the floating-point gate reads as zero at every level. When the table-jump extension is absent, the table gate ignores writes and reads as zero. A lower level can never show a bit that the level above it has clear.

The trap outputs are combinational from the decode inputs and the stored bits. A register write becomes visible from the next clock edge.

Top module: `stateen_gate`

## Requirements
- R1: After reset, all stored enable bits are zero and every level reads back 2'b00.
- R2: A write with `wr_en_i` high stores `wr_data_i` into the level chosen by `wr_lvl_i` (2'b00 machine, 2'b01 hypervisor, 2'b10 supervisor, 2'b11 no level). The new value is visible on `rd_data_o` after the next rising edge. Bit 0 of the data is the floating-point gate and bit 1 is the table gate. With no write, the stored bits hold.
- R3: While `cfg_fp_regs_i` is 1, bit 0 reads as zero at every level and a machine-level write cannot set it. In this state, floating-point instructions never trap in this block.
- R4: While `cfg_tbljmp_i` is 0, a machine-level write to bit 1 is dropped, so the bit still reads zero after the extension is later reported present. In this state, table-jump instructions and accesses to the table CSR never trap in this block.
- R5: The hypervisor level reads a bit as zero when the machine level has it clear. The supervisor level reads a bit as zero when the hypervisor level has it clear.
- R6: In machine mode (`priv_i` = 2'b11), no trap is raised, whatever the enable bits.
- R7: In any mode below machine (2'b00 user, 2'b01 supervisor), with or without virtualization, a gated operation whose machine-level bit is clear raises `trap_illegal_o`.
- R8: In VS or VU mode, if the machine-level bit is set and the hypervisor-level bit is clear, a gated operation raises `trap_virtual_o`.
- R9: If the machine and hypervisor bits allow the operation and the supervisor bit is clear, a gated operation raises an illegal trap in U mode and a virtual trap in VU mode. Supervisor mode is not gated by the supervisor level.
- R10: Bit 1 gates both the table-jump instructions and a CSR access whose address equals `VEC_CSR_ADDR` (default 12'h017). A CSR access to any other address is never trapped.
- R11: With `cfg_fp_regs_i` at 0, bit 0 gates every instruction flagged by `is_fp_op_i`, through the same level rules.
- R12: `trap_illegal_o` and `trap_virtual_o` are never both high. When one gate calls for an illegal trap and another calls for a virtual trap, only the illegal trap is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_fp_regs_i | input | 1 | 1 when a separate floating-point register file exists |
| cfg_tbljmp_i | input | 1 | 1 when the table-jump extension is present |
| wr_en_i | input | 1 | Enable-register write strobe |
| wr_lvl_i | input | 2 | Level written: 00 machine, 01 hypervisor, 10 supervisor |
| wr_data_i | input | 2 | Write data: bit 0 float gate, bit 1 table gate |
| rd_lvl_i | input | 2 | Level read, same encoding as `wr_lvl_i` |
| rd_data_o | output | 2 | Effective (masked) bits of the level being read |
| priv_i | input | 2 | Current privilege: 00 U, 01 S, 11 M |
| virt_i | input | 1 | Virtualization mode active |
| is_fp_op_i | input | 1 | Decoded instruction is floating point |
| is_tbljmp_op_i | input | 1 | Decoded instruction is a table jump |
| csr_acc_i | input | 1 | Decoded instruction accesses a CSR |
| csr_addr_i | input | 12 | Address of that CSR |
| trap_illegal_o | output | 1 | Illegal-instruction trap request |
| trap_virtual_o | output | 1 | Virtual-instruction trap request |

## Verification
The hardest case to reach is the one where the two gates disagree on the trap kind in the same cycle. In that case the floating-point gate must fail at the hypervisor level and the table gate must fail at the machine level, and the table decides which trap is reported. Decode flags of this kind do not occur together in real code, so the bench raises both flags at once on a purpose-built register set. The case where a write is dropped is also hard to observe. The bench writes the table bit while the extension is absent, then reports the extension present and reads the level back, which shows the write left nothing behind.

// File: rtl/stateen_gate_pkg.sv
package stateen_gate_pkg;

    localparam int NGATE    = 2;
    localparam int GATE_FLT = 0;
    localparam int GATE_VEC = 1;
    localparam int LVLW     = 2;
    localparam int PRVW     = 2;

    localparam logic [PRVW-1:0] PRV_U = 2'b00;
    localparam logic [PRVW-1:0] PRV_S = 2'b01;
    localparam logic [PRVW-1:0] PRV_M = 2'b11;

    localparam logic [LVLW-1:0] LVL_MACH = 2'b00;
    localparam logic [LVLW-1:0] LVL_HYP  = 2'b01;
    localparam logic [LVLW-1:0] LVL_SUP  = 2'b10;

    typedef logic [NGATE-1:0] gate_vec_t;

    typedef struct packed {
        gate_vec_t mach;
        gate_vec_t hyp;
        gate_vec_t sup;
    } gate_regs_t;

endpackage

// File: rtl/stateen_gate_regs.sv
module stateen_gate_regs
    import stateen_gate_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_fp_regs_i,
    input  logic            cfg_tbljmp_i,
    input  logic            wr_en_i,
    input  logic [LVLW-1:0] wr_lvl_i,
    input  gate_vec_t       wr_data_i,
    output gate_vec_t       mach_eff_o,
    output gate_vec_t       hyp_eff_o,
    output gate_vec_t       sup_eff_o
);

    gate_regs_t st_d, st_q;
    gate_vec_t  avail;

    // Bits the current configuration lets the machine level hold.
    always_comb begin
        avail           = '0;
        avail[GATE_FLT] = ~cfg_fp_regs_i;
        avail[GATE_VEC] = cfg_tbljmp_i;
    end

    always_comb begin
        st_d = st_q;
        if (wr_en_i) begin
            case (wr_lvl_i)
                LVL_MACH: st_d.mach = wr_data_i & avail;
                LVL_HYP:  st_d.hyp  = wr_data_i;
                LVL_SUP:  st_d.sup  = wr_data_i;
                default:  st_d      = st_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // Each level is masked by the one above it.
    assign mach_eff_o = st_q.mach & avail;
    assign hyp_eff_o  = st_q.hyp  & mach_eff_o;
    assign sup_eff_o  = st_q.sup  & hyp_eff_o;

    // R2: a hypervisor-level write lands unmodified
    a_r2_hyp_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_lvl_i == LVL_HYP) |=> st_q.hyp == $past(wr_data_i));

    // R2: stored bits hold without a write
    a_r2_hold_no_write: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en_i |=> $stable(st_q));

    // R4: table bit cannot be written while the extension is absent
    a_r4_vec_write_dropped: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_lvl_i == LVL_MACH && !cfg_tbljmp_i) |=> !st_q.mach[GATE_VEC]);

endmodule

// File: rtl/stateen_gate_eval.sv
module stateen_gate_eval
    import stateen_gate_pkg::*;
(
    input  logic            need_i,
    input  logic [PRVW-1:0] priv_i,
    input  logic            virt_i,
    input  logic            mach_i,
    input  logic            hyp_i,
    input  logic            sup_i,
    output logic            ill_o,
    output logic            vrt_o
);

    always_comb begin
        ill_o = 1'b0;
        vrt_o = 1'b0;
        if (need_i && priv_i != PRV_M) begin
            if (!mach_i) begin
                ill_o = 1'b1;
            end else if (virt_i && !hyp_i) begin
                vrt_o = 1'b1;
            end else if (priv_i == PRV_U && !sup_i) begin
                if (virt_i) vrt_o = 1'b1;
                else        ill_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/stateen_gate.sv
module stateen_gate
    import stateen_gate_pkg::*;
#(
    parameter logic [11:0] VEC_CSR_ADDR = 12'h017
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_fp_regs_i,
    input  logic        cfg_tbljmp_i,
    input  logic        wr_en_i,
    input  logic [1:0]  wr_lvl_i,
    input  logic [1:0]  wr_data_i,
    input  logic [1:0]  rd_lvl_i,
    output logic [1:0]  rd_data_o,
    input  logic [1:0]  priv_i,
    input  logic        virt_i,
    input  logic        is_fp_op_i,
    input  logic        is_tbljmp_op_i,
    input  logic        csr_acc_i,
    input  logic [11:0] csr_addr_i,
    output logic        trap_illegal_o,
    output logic        trap_virtual_o
);

    gate_vec_t mach_eff, hyp_eff, sup_eff;
    gate_vec_t need, ill_g, vrt_g;

    stateen_gate_regs u_regs (
        .clk           (clk),
        .rst_n         (rst_n),
        .cfg_fp_regs_i (cfg_fp_regs_i),
        .cfg_tbljmp_i  (cfg_tbljmp_i),
        .wr_en_i       (wr_en_i),
        .wr_lvl_i      (wr_lvl_i),
        .wr_data_i     (wr_data_i),
        .mach_eff_o    (mach_eff),
        .hyp_eff_o     (hyp_eff),
        .sup_eff_o     (sup_eff)
    );

    // Which gates the decoded instruction depends on.
    always_comb begin
        need           = '0;
        need[GATE_FLT] = is_fp_op_i & ~cfg_fp_regs_i;
        need[GATE_VEC] = cfg_tbljmp_i &
                         (is_tbljmp_op_i | (csr_acc_i && csr_addr_i == VEC_CSR_ADDR));
    end

    for (genvar g = 0; g < NGATE; g++) begin : g_gate
        stateen_gate_eval u_eval (
            .need_i (need[g]),
            .priv_i (priv_i),
            .virt_i (virt_i),
            .mach_i (mach_eff[g]),
            .hyp_i  (hyp_eff[g]),
            .sup_i  (sup_eff[g]),
            .ill_o  (ill_g[g]),
            .vrt_o  (vrt_g[g])
        );

        // R7: a clear machine bit below machine mode is always illegal
        a_r7_mach_clear_illegal: assert property (@(posedge clk) disable iff (!rst_n)
            (need[g] && priv_i != PRV_M && !mach_eff[g]) |-> trap_illegal_o);
    end

    always_comb begin
        trap_illegal_o = |ill_g;
        trap_virtual_o = ~trap_illegal_o & (|vrt_g);
    end

    always_comb begin
        case (rd_lvl_i)
            LVL_MACH: rd_data_o = mach_eff;
            LVL_HYP:  rd_data_o = hyp_eff;
            LVL_SUP:  rd_data_o = sup_eff;
            default:  rd_data_o = '0;
        endcase
    end

    // R6: machine mode is never blocked
    a_r6_mach_free: assert property (@(posedge clk) disable iff (!rst_n)
        (priv_i == PRV_M) |-> (!trap_illegal_o && !trap_virtual_o));

    // R12: at most one trap kind per cycle
    a_r12_one_kind: assert property (@(posedge clk) disable iff (!rst_n)
        !(trap_illegal_o && trap_virtual_o));

endmodule

// File: tb/stateen_gate_tb.sv
module stateen_gate_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_fp_regs_i = 1'b0, cfg_tbljmp_i = 1'b1;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_lvl_i = 2'b00, wr_data_i = 2'b00, rd_lvl_i = 2'b00;
    logic [1:0]  rd_data_o;
    logic [1:0]  priv_i = 2'b11;
    logic        virt_i = 1'b0, is_fp_op_i = 1'b0, is_tbljmp_op_i = 1'b0, csr_acc_i = 1'b0;
    logic [11:0] csr_addr_i = 12'h000;
    logic        trap_illegal_o, trap_virtual_o;

    int checks = 0;
    int failures = 0;

    always #4 clk = ~clk;

    stateen_gate u_dut (.*);

    // [15:14]mach [13:12]hyp [11:10]sup [9]fp_regs [8]tbljmp [7:6]priv [5]virt
    // [4]fp_op [3]tj_op [2]csr@table-addr [1]exp_illegal [0]exp_virtual
    localparam int NV = 16;
    localparam logic [15:0] VEC [NV] = '{
        16'b00_00_00_0_1_11_0_1_1_1_0_0, // R6 machine mode free
        16'b00_11_11_0_1_01_0_0_1_0_1_0, // R7 S mode, mach clear
        16'b00_11_11_0_1_01_1_1_0_0_1_0, // R7 VS fp, mach clear
        16'b11_01_11_0_1_01_1_0_1_0_0_1, // R8 VS, hyp clear
        16'b11_01_11_0_1_00_1_0_1_0_0_1, // R8 VU, hyp clear
        16'b11_11_01_0_1_00_0_0_1_0_1_0, // R9 U, sup clear
        16'b11_11_01_0_1_00_1_0_1_0_0_1, // R9 VU, sup clear
        16'b11_11_01_0_1_01_0_0_1_0_0_0, // R9 S mode not sup-gated
        16'b11_11_11_0_1_00_1_0_1_0_0_0, // R9 all set, VU passes
        16'b01_11_11_0_1_00_0_0_0_1_1_0, // R10 table CSR, mach clear
        16'b11_11_11_0_1_00_0_0_0_1_0_0, // R10 table CSR allowed
        16'b10_11_11_0_1_00_0_1_0_0_1_0, // R11 fp, mach clear
        16'b01_11_10_0_1_00_1_1_0_0_0_1, // R11 fp VU, sup clear
        16'b00_00_00_1_1_00_0_1_0_0_0_0, // R3 fp regs present, no gating
        16'b00_00_00_0_0_00_0_0_1_1_0_0, // R4 extension absent, no gating
        16'b01_10_11_0_1_01_1_1_1_0_1_0  // R12 illegal beats virtual
    };

    task automatic chk(input string req, input logic [1:0] act, input logic [1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%b expected=%b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] lvl, input logic [1:0] d);
        @(negedge clk);
        wr_en_i = 1'b1; wr_lvl_i = lvl; wr_data_i = d;
        @(negedge clk);
        wr_en_i = 1'b0;
    endtask

    task automatic rd(input string req, input logic [1:0] lvl, input logic [1:0] exp);
        @(negedge clk);
        rd_lvl_i = lvl;
        #1 chk(req, rd_data_o, exp);
    endtask

    initial begin
        #1600000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        rd("R1 mach", 2'b00, 2'b00);
        rd("R1 hyp", 2'b01, 2'b00);
        rd("R1 sup", 2'b10, 2'b00);
        #1 chk("R1 traps idle", {trap_illegal_o, trap_virtual_o}, 2'b00);

        for (int i = 0; i < NV; i++) begin
            logic [15:0] v;
            v = VEC[i];
            @(negedge clk);
            cfg_fp_regs_i = v[9]; cfg_tbljmp_i = v[8];
            is_fp_op_i = 1'b0; is_tbljmp_op_i = 1'b0; csr_acc_i = 1'b0;
            wr(2'b00, v[15:14]);
            wr(2'b01, v[13:12]);
            wr(2'b10, v[11:10]);
            @(negedge clk);
            priv_i = v[7:6]; virt_i = v[5];
            is_fp_op_i = v[4]; is_tbljmp_op_i = v[3];
            csr_acc_i = v[2]; csr_addr_i = 12'h017;
            #2 chk($sformatf("vector %0d (R6-R12)", i),
                   {trap_illegal_o, trap_virtual_o}, v[1:0]);
        end

        // R10 other CSR address never trapped
        @(negedge clk);
        is_fp_op_i = 1'b0; is_tbljmp_op_i = 1'b0;
        cfg_fp_regs_i = 1'b0; cfg_tbljmp_i = 1'b1;
        wr(2'b00, 2'b00);
        @(negedge clk);
        priv_i = 2'b00; virt_i = 1'b0; csr_acc_i = 1'b1; csr_addr_i = 12'h018;
        #2 chk("R10 other CSR", {trap_illegal_o, trap_virtual_o}, 2'b00);
        csr_addr_i = 12'h017;
        #1 chk("R10 table CSR", {trap_illegal_o, trap_virtual_o}, 2'b10);
        csr_acc_i = 1'b0;

        // R2 write and read back
        wr(2'b00, 2'b11);
        wr(2'b01, 2'b10);
        rd("R2 hyp readback", 2'b01, 2'b10);
        wr(2'b11, 2'b00);
        rd("R2 no-level write", 2'b00, 2'b11);

        // R5 lower level masked by upper
        wr(2'b00, 2'b01);
        wr(2'b01, 2'b11);
        wr(2'b10, 2'b11);
        rd("R5 hyp masked", 2'b01, 2'b01);
        rd("R5 sup masked", 2'b10, 2'b01);
        wr(2'b01, 2'b00);
        rd("R5 sup under clear hyp", 2'b10, 2'b00);

        // R3 float gate read-only zero
        @(negedge clk); cfg_fp_regs_i = 1'b1;
        wr(2'b00, 2'b11);
        rd("R3 mach bit0 zero", 2'b00, 2'b10);
        @(negedge clk); cfg_fp_regs_i = 1'b0;
        rd("R3 write not stored", 2'b00, 2'b10);

        // R4 table gate write dropped while absent
        @(negedge clk); cfg_tbljmp_i = 1'b0;
        wr(2'b00, 2'b11);
        rd("R4 absent reads zero", 2'b00, 2'b01);
        @(negedge clk); cfg_tbljmp_i = 1'b1;
        rd("R4 write left nothing", 2'b00, 2'b01);

        repeat (2) @(negedge clk);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule